// File: doc/BRIEF.md
# Two-Level CRC Packet Framer and Checker

This block frames variable-length packets onto a byte-wide link and checks them again at the far end. The transmit side accepts a set of header fields plus a payload byte stream. It sends an eight-byte header, the payload, a three-byte packet CRC and a final marker byte. The last header byte is a CRC-8 over the seven bytes before it, so a receiver can judge the header before any payload arrives. The packet CRC is a 24-bit CRC over the header and the payload. The marker byte lets a sender that has already started sending declare the packet bad, because the marker goes out last.

The receive side parses the same stream with no backpressure. It decodes the header fields and raises a header error one cycle after byte 7 if the header CRC does not match. When the marker byte arrives it gives its verdict: packet-CRC error, good, poisoned or corrupt marker. The packet length is always a whole number of 32-byte chunks, from 32 to 256 bytes, and it is taken from the header size field.

Top module: `pfcLink`

## Requirements
- R1: A frame is 32*(N+1) bytes long, where N is the 3-bit size code. Byte 0 is the destination, byte 1 is {vc[2:0], N[2:0], 2'b00}, byte 2 is the credit field and bytes 3..6 are the tag with the most significant byte first. The framer goes idle after the last byte.
- R2: Byte 7 is a CRC-8 with polynomial 0x07 and initial value 0x00, computed MSB-first over bytes 0..6.
- R3: Bytes L-4..L-2 carry a CRC-24 with polynomial 0x864CFB and initial value 0xB704CE, computed MSB-first over bytes 0..L-5 and sent most significant byte first.
- R4: The last byte is 0xA5. It is 0x00 if txPoison was high in any cycle from the start acceptance until the marker byte is presented.
- R5: While linkReady is low, a presented header, CRC or marker byte holds its value. A payload byte is taken from the payload stream only in a cycle where the link accepts it, and payload bytes appear in order at bytes 8..L-5.
- R6: txReady is high only while the framer is idle. A txStart while busy is ignored and does not change the packet in flight.
- R7: After byte 7 is received, rxHdrValid is high and rxDest, rxVc, rxSize, rxCredit and rxTag show the received header fields.
- R8: rxHdrErr rises in the cycle after byte 7 is accepted if that byte differs from the CRC-8 of bytes 0..6. It stays high until the next frame starts.
- R9: rxDone pulses for one cycle after the last byte. rxCrcErr is then high if the received CRC-24 differs from the CRC-24 recomputed over bytes 0..L-5.
- R10: With rxDone, rxPktValid is high only if both CRCs match and the marker is 0xA5. rxPoisoned is high for a marker of 0x00, and rxCorrupt is high for any other marker value.
- R11: After reset: txReady=1, linkValid=0, txPayReady=0, rxDone=0, rxHdrValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txStart | input | 1 | Start a packet with the presented fields |
| txReady | output | 1 | Framer idle, start accepted |
| txDest | input | 8 | Destination field |
| txVc | input | 3 | Virtual channel field |
| txSize | input | 3 | Length code N, length 32*(N+1) |
| txCredit | input | 8 | Link flow-control credit field |
| txTag | input | 32 | Free tag field |
| txPoison | input | 1 | Mark the packet in flight bad |
| txPayValid | input | 1 | Payload byte available |
| txPayReady | output | 1 | Payload byte consumed |
| txPayData | input | 8 | Payload byte |
| linkValid | output | 1 | Link byte valid |
| linkReady | input | 1 | Link accepts byte |
| linkData | output | 8 | Link byte |
| rxValid | input | 1 | Received byte valid |
| rxData | input | 8 | Received byte |
| rxHdrValid | output | 1 | Decoded header fields valid |
| rxHdrErr | output | 1 | Header CRC mismatch |
| rxDest | output | 8 | Decoded destination |
| rxVc | output | 3 | Decoded virtual channel |
| rxSize | output | 3 | Decoded length code |
| rxCredit | output | 8 | Decoded credit field |
| rxTag | output | 32 | Decoded tag |
| rxDone | output | 1 | One-cycle end-of-frame pulse |
| rxCrcErr | output | 1 | Packet CRC mismatch |
| rxPktValid | output | 1 | Packet judged good |
| rxPoisoned | output | 1 | Marker was the poison value |
| rxCorrupt | output | 1 | Marker was neither legal value |

## Verification
A single flipped bit in byte 7 hits both checks in the receiver. The header check reports it one cycle after that byte, and the packet CRC, which also covers byte 7, reports it at the end of the frame. The bench provokes this by corrupting byte 7 on the way from link to receiver. It then judges that rxHdrErr rises exactly one cycle after byte 7 and that rxCrcErr is also set in the same verdict. On the transmit side, a second start request is driven while a short frame is already in flight. The frame length and destination must stay those of the first request, and the link must go quiet afterwards.

// File: rtl/pfcPkg.sv
package pfcPkg;
  localparam int SIZE_W     = 3;
  localparam int CHUNK_LOG2 = 5;
  localparam int CNT_W      = SIZE_W + CHUNK_LOG2;
  localparam int VC_W       = 3;
  localparam int TAG_W      = 32;
  localparam int HDR_FIELDS = 7;
  localparam logic [7:0]  CRC8_POLY  = 8'h07;
  localparam logic [7:0]  CRC8_INIT  = 8'h00;
  localparam logic [23:0] CRC24_POLY = 24'h864CFB;
  localparam logic [23:0] CRC24_INIT = 24'hB704CE;
  localparam logic [7:0]  MARK_GOOD  = 8'hA5;
  localparam logic [7:0]  MARK_BAD   = 8'h00;

  typedef enum logic [2:0] {SEL_HDR, SEL_HCRC, SEL_PAY, SEL_PCRC, SEL_MARK} byteSel_e;

  typedef struct packed {
    logic     load;
    logic     crcEn;
    byteSel_e sel;
    logic [2:0] hdrIdx;
    logic [1:0] crcIdx;
    logic     poisonMark;
  } txStrobe_t;

  function automatic logic [7:0] crc8Byte(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ CRC8_POLY) : (c << 1);
    return c;
  endfunction

  function automatic logic [23:0] crc24Byte(input logic [23:0] crc, input logic [7:0] b);
    logic [23:0] c;
    c = crc ^ {b, 16'h0000};
    for (int i = 0; i < 8; i++) c = c[23] ? ((c << 1) ^ CRC24_POLY) : (c << 1);
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] lastIndex(input logic [SIZE_W-1:0] s);
    return {s, {CHUNK_LOG2{1'b1}}};
  endfunction

  function automatic logic [HDR_FIELDS-1:0][7:0] packHeader(
      input logic [7:0] dest, input logic [VC_W-1:0] vc, input logic [SIZE_W-1:0] size,
      input logic [7:0] credit, input logic [TAG_W-1:0] tag);
    logic [HDR_FIELDS-1:0][7:0] h;
    h[0] = dest;
    h[1] = {vc, size, 2'b00};
    h[2] = credit;
    h[3] = tag[31:24];
    h[4] = tag[23:16];
    h[5] = tag[15:8];
    h[6] = tag[7:0];
    return h;
  endfunction
endpackage

// File: rtl/pfcTxCtrl.sv
module pfcTxCtrl
  import pfcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic              poison,
  input  logic              payValid,
  input  logic              linkReady,
  output logic              txReady,
  output logic              linkValid,
  output logic              payReady,
  output txStrobe_t         stb
);
  localparam logic [CNT_W-1:0] TRAILER = CNT_W'(3);
  localparam logic [CNT_W-1:0] HCRC_AT = CNT_W'(7);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [SIZE_W-1:0] size;
  logic              poisonFlag;
  logic [CNT_W-1:0]  last;
  logic [CNT_W-1:0]  crcOfs;
  logic              fire;

  assign last   = lastIndex(size);
  assign crcOfs = cnt - (last - TRAILER);

  always_comb begin
    if (cnt < HCRC_AT)              stb.sel = SEL_HDR;
    else if (cnt == HCRC_AT)        stb.sel = SEL_HCRC;
    else if (cnt < last - TRAILER)  stb.sel = SEL_PAY;
    else if (cnt < last)            stb.sel = SEL_PCRC;
    else                            stb.sel = SEL_MARK;
  end

  assign txReady        = !busy;
  assign linkValid      = busy && (stb.sel != SEL_PAY || payValid);
  assign payReady       = busy && stb.sel == SEL_PAY && linkReady;
  assign fire           = linkValid && linkReady;
  assign stb.load       = start && !busy;
  assign stb.crcEn      = fire && (stb.sel == SEL_HDR || stb.sel == SEL_HCRC || stb.sel == SEL_PAY);
  assign stb.hdrIdx     = cnt[2:0];
  assign stb.crcIdx     = crcOfs[1:0];
  assign stb.poisonMark = poisonFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      cnt        <= '0;
      size       <= '0;
      poisonFlag <= 1'b0;
    end else if (stb.load) begin
      busy       <= 1'b1;
      cnt        <= '0;
      size       <= sizeCode;
      poisonFlag <= poison;
    end else if (busy) begin
      if (poison && stb.sel != SEL_MARK) poisonFlag <= 1'b1;
      if (fire) begin
        if (cnt == last) busy <= 1'b0;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: the marker byte closes the frame
  p_frame_end_r1: assert property (@(posedge clk) disable iff (!rstN)
    fire && stb.sel == SEL_MARK |=> !busy && !linkValid);
  // R6: a start while busy leaves the frame length alone
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy && !(fire && stb.sel == SEL_MARK) |=> busy && $stable(size));
  // R5: payload taken only when the link accepts
  p_pay_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    payReady |-> linkReady && stb.sel == SEL_PAY);
endmodule

// File: rtl/pfcTxPath.sv
module pfcTxPath
  import pfcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [7:0]        dest,
  input  logic [VC_W-1:0]   vc,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [7:0]        credit,
  input  logic [TAG_W-1:0]  tag,
  input  logic [7:0]        payData,
  output logic [7:0]        linkData
);
  logic [HDR_FIELDS-1:0][7:0] hdrNext;
  logic [HDR_FIELDS-1:0][7:0] hdrB;
  logic [7:0]  hdrCrc;
  logic [7:0]  hdrCrcNext;
  logic [23:0] pktCrc;

  assign hdrNext = packHeader(dest, vc, sizeCode, credit, tag);

  always_comb begin
    hdrCrcNext = CRC8_INIT;
    for (int k = 0; k < HDR_FIELDS; k++) hdrCrcNext = crc8Byte(hdrCrcNext, hdrNext[k]);
  end

  always_comb begin
    unique case (stb.sel)
      SEL_HDR:  linkData = hdrB[stb.hdrIdx];
      SEL_HCRC: linkData = hdrCrc;
      SEL_PAY:  linkData = payData;
      SEL_PCRC: linkData = (stb.crcIdx == 2'd0) ? pktCrc[23:16] :
                           (stb.crcIdx == 2'd1) ? pktCrc[15:8] : pktCrc[7:0];
      default:  linkData = stb.poisonMark ? MARK_BAD : MARK_GOOD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrB   <= '0;
      hdrCrc <= CRC8_INIT;
      pktCrc <= CRC24_INIT;
    end else if (stb.load) begin
      hdrB   <= hdrNext;
      hdrCrc <= hdrCrcNext;
      pktCrc <= CRC24_INIT;
    end else if (stb.crcEn) begin
      pktCrc <= crc24Byte(pktCrc, linkData);
    end
  end
endmodule

// File: rtl/pfcRxCheck.sv
module pfcRxCheck
  import pfcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              hdrValid,
  output logic              hdrErr,
  output logic [7:0]        dest,
  output logic [VC_W-1:0]   vc,
  output logic [SIZE_W-1:0] sizeCode,
  output logic [7:0]        credit,
  output logic [TAG_W-1:0]  tag,
  output logic              done,
  output logic              crcErr,
  output logic              pktValid,
  output logic              poisoned,
  output logic              corrupt
);
  localparam logic [CNT_W-1:0] TRAILER = CNT_W'(3);
  localparam logic [CNT_W-1:0] HCRC_AT = CNT_W'(7);

  logic [CNT_W-1:0]  cnt;
  logic [SIZE_W-1:0] size;
  logic [HDR_FIELDS-1:0][7:0] hdrB;
  logic [7:0]  crc8;
  logic [23:0] crc24;
  logic [23:0] rxCrc;
  logic [CNT_W-1:0] last;
  logic [7:0]  crc8Base;
  logic [23:0] crc24Base;

  assign last      = lastIndex(size);
  assign crc8Base  = (cnt == '0) ? CRC8_INIT  : crc8;
  assign crc24Base = (cnt == '0) ? CRC24_INIT : crc24;

  assign dest     = hdrB[0];
  assign vc       = hdrB[1][7:5];
  assign sizeCode = hdrB[1][4:2];
  assign credit   = hdrB[2];
  assign tag      = {hdrB[3], hdrB[4], hdrB[5], hdrB[6]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0; size <= '0; hdrB <= '0; crc8 <= CRC8_INIT; crc24 <= CRC24_INIT;
      rxCrc <= '0; hdrValid <= 1'b0; hdrErr <= 1'b0; done <= 1'b0;
      crcErr <= 1'b0; pktValid <= 1'b0; poisoned <= 1'b0; corrupt <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rxValid) begin
        cnt <= cnt + 1'b1;
        if (cnt < HCRC_AT) begin
          crc8  <= crc8Byte(crc8Base, rxData);
          crc24 <= crc24Byte(crc24Base, rxData);
          hdrB[cnt[2:0]] <= rxData;
          if (cnt == CNT_W'(1)) size <= rxData[4:2];
          if (cnt == '0) begin
            hdrValid <= 1'b0;
            hdrErr   <= 1'b0;
          end
        end else if (cnt == HCRC_AT) begin
          hdrErr   <= (rxData != crc8);
          hdrValid <= 1'b1;
          crc24    <= crc24Byte(crc24, rxData);
        end else if (cnt < last - TRAILER) begin
          crc24 <= crc24Byte(crc24, rxData);
        end else if (cnt < last) begin
          rxCrc <= {rxCrc[15:0], rxData};
        end else begin
          cnt      <= '0;
          done     <= 1'b1;
          crcErr   <= (rxCrc != crc24);
          pktValid <= !hdrErr && (rxCrc == crc24) && (rxData == MARK_GOOD);
          poisoned <= (rxData == MARK_BAD);
          corrupt  <= (rxData != MARK_GOOD) && (rxData != MARK_BAD);
        end
      end
    end
  end

  // R8: a header error appears only right after byte 7
  p_hdr_err_timing_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hdrErr) |-> $past(rxValid) && $past(cnt) == HCRC_AT);
  // R9: every verdict comes after a decoded header
  p_done_after_hdr_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> hdrValid);
  // R10: at most one marker verdict at a time
  p_verdict_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pktValid, poisoned, corrupt}));
  // R10: a good packet has no CRC error of either kind
  p_good_clean_r10: assert property (@(posedge clk) disable iff (!rstN)
    done && pktValid |-> !hdrErr && !crcErr);
endmodule

// File: rtl/pfcLink.sv
module pfcLink
  import pfcPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txStart,
  output logic        txReady,
  input  logic [7:0]  txDest,
  input  logic [2:0]  txVc,
  input  logic [2:0]  txSize,
  input  logic [7:0]  txCredit,
  input  logic [31:0] txTag,
  input  logic        txPoison,
  input  logic        txPayValid,
  output logic        txPayReady,
  input  logic [7:0]  txPayData,
  output logic        linkValid,
  input  logic        linkReady,
  output logic [7:0]  linkData,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  output logic        rxHdrValid,
  output logic        rxHdrErr,
  output logic [7:0]  rxDest,
  output logic [2:0]  rxVc,
  output logic [2:0]  rxSize,
  output logic [7:0]  rxCredit,
  output logic [31:0] rxTag,
  output logic        rxDone,
  output logic        rxCrcErr,
  output logic        rxPktValid,
  output logic        rxPoisoned,
  output logic        rxCorrupt
);
  txStrobe_t stb;

  pfcTxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(txStart), .sizeCode(txSize), .poison(txPoison),
    .payValid(txPayValid), .linkReady(linkReady), .txReady(txReady),
    .linkValid(linkValid), .payReady(txPayReady), .stb(stb));

  pfcTxPath u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .dest(txDest), .vc(txVc), .sizeCode(txSize),
    .credit(txCredit), .tag(txTag), .payData(txPayData), .linkData(linkData));

  pfcRxCheck u_rx (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .hdrValid(rxHdrValid), .hdrErr(rxHdrErr), .dest(rxDest), .vc(rxVc),
    .sizeCode(rxSize), .credit(rxCredit), .tag(rxTag), .done(rxDone),
    .crcErr(rxCrcErr), .pktValid(rxPktValid), .poisoned(rxPoisoned), .corrupt(rxCorrupt));

  // R5: a stalled non-payload byte holds still
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    linkValid && !linkReady && stb.sel != SEL_PAY |=> linkValid && $stable(linkData));
endmodule

// File: tb/pfcLink_tb.sv
module pfcLink_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txStart = 1'b0, txPoison = 1'b0, txPayValid = 1'b1, linkReady = 1'b1;
  logic [7:0] txDest = '0, txCredit = '0;
  logic [2:0] txVc = '0, txSize = '0;
  logic [31:0] txTag = '0;
  logic [7:0] txPayData, linkData, rxData, rxDest, rxCredit;
  logic txReady, txPayReady, linkValid, rxValid, rxHdrValid, rxHdrErr, rxDone;
  logic rxCrcErr, rxPktValid, rxPoisoned, rxCorrupt;
  logic [2:0] rxVc, rxSize;
  logic [31:0] rxTag;

  int nChecks = 0, nFails = 0, cyc = 0, byteIdx = 0, b7Cyc = 0, hdrCyc = 0;
  int injIdx = 1000, injBit = 0, pktNum = 0;
  bit hdrSeen = 0, stallOn = 0;
  logic [7:0] lfsr = 8'h5B;
  logic [7:0] cap [0:255];

  always #5 clk = ~clk;

  pfcLink u_dut (.*);

  function automatic logic [7:0] payByte(input int pn, input int idx);
    return 8'((pn * 7) + (idx * 13) + 3);
  endfunction

  assign txPayData = payByte(pktNum, byteIdx);
  assign rxValid   = linkValid & linkReady;
  assign rxData    = linkData ^ ((byteIdx == injIdx) ? (8'h01 << injBit) : 8'h00);

  function automatic logic [7:0] mCrc8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic logic [23:0] mCrc24(input logic [23:0] c, input logic [7:0] b);
    logic [23:0] r = c ^ {b, 16'h0};
    for (int i = 0; i < 8; i++) r = r[23] ? ((r << 1) ^ 24'h864CFB) : (r << 1);
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (txStart && txReady) begin
      byteIdx = 0;
      hdrSeen = 0;
    end else if (linkValid && linkReady) begin
      cap[byteIdx] = linkData;
      if (byteIdx == 7) b7Cyc = cyc;
      byteIdx++;
    end
    if (rxHdrErr && !hdrSeen && byteIdx >= 8) begin
      hdrSeen = 1;
      hdrCyc = cyc;
    end
    if (cyc == 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    linkReady <= stallOn ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0] size; logic poison; logic [2:0] kind; logic [2:0] bitSel; logic stall;
    logic eHdr; logic eCrc; logic eOk; logic ePois; logic eCorr;
  } vec_t;

  // kind: 0 none, 1 byte 0, 2 byte 7, 3 payload byte 20, 4 CRC byte L-4, 5 CRC byte L-2, 6 marker
  localparam vec_t VECS [16] = '{
    '{3'd0,1'b0,3'd0,3'd0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0},
    '{3'd1,1'b0,3'd0,3'd0,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b0},
    '{3'd2,1'b0,3'd0,3'd0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0},
    '{3'd3,1'b0,3'd0,3'd0,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b0},
    '{3'd4,1'b0,3'd0,3'd0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0},
    '{3'd5,1'b0,3'd0,3'd0,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b0},
    '{3'd6,1'b0,3'd0,3'd0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0},
    '{3'd7,1'b0,3'd0,3'd0,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b0},
    '{3'd2,1'b0,3'd1,3'd3,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0},
    '{3'd0,1'b0,3'd2,3'd0,1'b1, 1'b1,1'b1,1'b0,1'b0,1'b0},
    '{3'd5,1'b0,3'd3,3'd6,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0},
    '{3'd7,1'b0,3'd4,3'd7,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0},
    '{3'd3,1'b0,3'd5,3'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0},
    '{3'd1,1'b0,3'd6,3'd2,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{3'd4,1'b1,3'd0,3'd0,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0},
    '{3'd6,1'b1,3'd3,3'd1,1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0}
  };

  task automatic sendPacket(input vec_t v, input bit intrude);
    int L = 32 * (int'(v.size) + 1);
    logic [7:0] exp [0:255];
    logic [7:0] c8;
    logic [23:0] c24;
    int badHdr = 0, badPay = 0;
    logic [7:0] d = 8'h10 + 8'(pktNum);
    logic [2:0] vcv = 3'(pktNum);
    logic [7:0] cr = 8'hC0 ^ 8'(pktNum);
    logic [31:0] tg = 32'hDEAD0000 + 32'(pktNum) * 32'h1111;
    case (v.kind)
      3'd1: injIdx = 0;
      3'd2: injIdx = 7;
      3'd3: injIdx = 20;
      3'd4: injIdx = L - 4;
      3'd5: injIdx = L - 2;
      3'd6: injIdx = L - 1;
      default: injIdx = 1000;
    endcase
    injBit = int'(v.bitSel);
    stallOn = v.stall;
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txDest = d; txVc = vcv; txSize = v.size; txCredit = cr; txTag = tg;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    if (v.poison) begin
      repeat (10) @(negedge clk);
      txPoison = 1'b1;
      @(negedge clk);
      txPoison = 1'b0;
    end
    if (intrude) begin
      repeat (4) @(negedge clk);
      chk(txReady == 1'b0, "R6", "txReady while busy", longint'(txReady), 0);
      txStart = 1'b1; txSize = 3'd7; txDest = 8'hEE;
      @(negedge clk);
      txStart = 1'b0; txSize = v.size; txDest = d;
    end
    while (!rxDone) @(negedge clk);
    // expected frame from the requirements
    exp[0] = d; exp[1] = {vcv, v.size, 2'b00}; exp[2] = cr;
    exp[3] = tg[31:24]; exp[4] = tg[23:16]; exp[5] = tg[15:8]; exp[6] = tg[7:0];
    c8 = 8'h00;
    for (int k = 0; k < 7; k++) c8 = mCrc8(c8, exp[k]);
    exp[7] = c8;
    for (int k = 8; k < L - 4; k++) exp[k] = payByte(pktNum, k);
    c24 = 24'hB704CE;
    for (int k = 0; k < L - 4; k++) c24 = mCrc24(c24, exp[k]);
    for (int k = 0; k < 7; k++) if (cap[k] !== exp[k]) badHdr++;
    for (int k = 8; k < L - 4; k++) if (cap[k] !== exp[k]) badPay++;
    chk(byteIdx == L, "R1", "frame length", longint'(byteIdx), longint'(L));
    chk(badHdr == 0, "R1", "header byte mismatches", longint'(badHdr), 0);
    chk(cap[7] == c8, "R2", "header CRC byte", longint'(cap[7]), longint'(c8));
    chk({cap[L-4], cap[L-3], cap[L-2]} == c24, "R3", "packet CRC bytes",
        longint'({cap[L-4], cap[L-3], cap[L-2]}), longint'(c24));
    chk(cap[L-1] == (v.poison ? 8'h00 : 8'hA5), "R4", "marker byte",
        longint'(cap[L-1]), longint'(v.poison ? 8'h00 : 8'hA5));
    chk(badPay == 0, "R5", "payload byte mismatches", longint'(badPay), 0);
    chk(rxHdrErr == v.eHdr, "R8", "header error flag", longint'(rxHdrErr), longint'(v.eHdr));
    if (v.eHdr)
      chk(hdrSeen && hdrCyc == b7Cyc + 1, "R8", "header error cycle",
          longint'(hdrCyc), longint'(b7Cyc + 1));
    chk(rxCrcErr == v.eCrc, "R9", "packet CRC error flag", longint'(rxCrcErr), longint'(v.eCrc));
    chk(rxPktValid == v.eOk, "R10", "packet valid", longint'(rxPktValid), longint'(v.eOk));
    chk(rxPoisoned == v.ePois, "R10", "poisoned", longint'(rxPoisoned), longint'(v.ePois));
    chk(rxCorrupt == v.eCorr, "R10", "corrupt marker", longint'(rxCorrupt), longint'(v.eCorr));
    if (!v.eHdr)
      chk(rxHdrValid && rxDest == d && rxVc == vcv && rxSize == v.size && rxCredit == cr && rxTag == tg,
          "R7", "decoded fields", longint'({rxDest, rxVc, rxSize, rxTag}),
          longint'({d, vcv, v.size, tg}));
    stallOn = 1'b0;
    injIdx = 1000;
    pktNum++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txReady == 1'b1, "R11", "reset txReady", longint'(txReady), 1);
    chk(linkValid == 1'b0, "R11", "reset linkValid", longint'(linkValid), 0);
    chk(txPayReady == 1'b0, "R11", "reset txPayReady", longint'(txPayReady), 0);
    chk(rxDone == 1'b0 && rxHdrValid == 1'b0, "R11", "reset receive flags",
        longint'({rxDone, rxHdrValid}), 0);
    foreach (VECS[i]) sendPacket(VECS[i], 1'b0);
    // R6: a second start during a short frame is ignored
    sendPacket('{3'd1,1'b0,3'd0,3'd0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0}, 1'b1);
    repeat (3) @(negedge clk);
    chk(linkValid == 1'b0 && txReady == 1'b1, "R6", "quiet after ignored start",
        longint'({linkValid, txReady}), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule